// File: doc/BRIEF.md
# Synchronous Burst SRAM Cycle Controller

This block is the control path and storage of a single-port, byte-writable burst SRAM that sits on a clocked bus. On every rising clock edge it samples three chip enables, two address strobes, a burst-advance input, the write controls and a sleep input. From these it decides what the cycle is: sleep, deselect, begin burst, continue burst or suspend burst. It keeps a four-beat linear burst counter, writes byte lanes into an internal array, and drives the shared data bus. The output enable acts without the clock.

The processor strobe only takes effect when the first enable is active, and it always starts a read. The controller strobe can start either a read or a write. Once a burst is open, the advance input steps the address or holds it, and each beat is a read or a write. Reads use flow-through timing: the word at the registered address appears on the bus in the clock period that follows the edge that selected it. Write data is captured from the bus at the edge of the write cycle.

Top module: `sbs_sram_ctl`

## Requirements
- R1: After reset no burst is open. Continue and suspend cycles leave the data bus in high impedance even with output enable low.
- R2: While `sleep` is high every other control is ignored. No write takes place and the bus stays in high impedance. After sleep ends, continue and suspend cycles have no effect until a new burst starts.
- R3: A strobe start is a deselect when `ce_b` is low or `ce_c_n` is high (processor strobe with `ce_a_n` low, or controller strobe), or when `ce_a_n` is high with the controller strobe low. A deselect uses no address and leaves the bus in high impedance.
- R4: While `ce_a_n` is high the processor strobe is ignored. With the controller strobe high the cycle is a continue (`adv_n` low) or a suspend (`adv_n` high) of the open burst.
- R5: `ads_cpu_n` low with `ce_a_n` low and the chip enabled latches `addr` and starts a read, even when `gw_n` is low and the bus carries data. No write occurs on that edge.
- R6: `ads_ctl_n` low with `ads_cpu_n` high and the chip enabled latches `addr` and starts a write if the write term is active, otherwise a read.
- R7: The write term is active when `gw_n` is low, or when `bwe_n` is low and at least one bit of `lane_n` is low. With `bwe_n` low and `lane_n` all high, or with `bwe_n` and `gw_n` high, the cycle is a read.
- R8: A continue cycle (both strobes high, `adv_n` low) increments address bits [1:0] modulo 4 and keeps bits [5:2].
- R9: A suspend cycle (both strobes high, `adv_n` high) keeps the current address.
- R10: The bus is driven only during read cycles while `oe_n` is low. `oe_n` acts without the clock. The bus is in high impedance during write cycles, whatever the value of `oe_n`.
- R11: A byte write stores lane k (`dq[9k+8:9k]`) only where `lane_n[k]` is low. A global write (`gw_n` low) stores all four lanes.
- R12: After a deselect, a continue or suspend cycle performs no write and does not drive the bus.
- R13: Read data for the address chosen at an edge is valid on `dq` in the same clock period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock, rising edge |
| rst | input | 1 | Synchronous active-high reset of the control state |
| ce_a_n | input | 1 | First chip enable, active low, also gates the processor strobe |
| ce_b | input | 1 | Second chip enable, active high |
| ce_c_n | input | 1 | Third chip enable, active low |
| ads_cpu_n | input | 1 | Processor address strobe, active low, always starts a read |
| ads_ctl_n | input | 1 | Controller address strobe, active low, starts a read or a write |
| adv_n | input | 1 | Burst advance, low = next address, high = hold |
| gw_n | input | 1 | Global write, active low, all lanes |
| bwe_n | input | 1 | Byte-write enable, active low, qualifies `lane_n` |
| lane_n | input | 4 | Per-lane byte enables, active low |
| sleep | input | 1 | Power-down request, active high |
| oe_n | input | 1 | Output enable, active low, acts without the clock |
| addr | input | 6 | External word address |
| dq | inout | 36 | Shared data bus, four 9-bit lanes |

## Verification
The case that is hardest to bring about is a start or sleep edge that lands while the bus carries write data and the write controls are asserted. The processor strobe and sleep must both refuse that write. To reach it, the bench drives a distinctive value on the bus together with `gw_n` low at such an edge. Output enable is held high across the edge so that there is no bus contention. The bench then reopens a read burst at the same address and shows that the word did not change. The same stale-data method shows that a continue write after a deselect stores nothing.

// File: rtl/sbs_pkg.sv
package sbs_pkg;

    // Burst length is fixed at four beats in linear order.
    localparam int BURST_W = 2;

    typedef enum logic [2:0] {
        CYC_SLEEP,
        CYC_DESEL,
        CYC_BEGIN,
        CYC_NEXT,
        CYC_HOLD
    } cyc_e;

    typedef enum logic [1:0] {
        BUS_OFF,
        BUS_READ,
        BUS_WRITE
    } bus_e;

    typedef struct packed {
        cyc_e kind;
        bus_e dir;
    } cmd_t;

    // All three enables in their active state.
    function automatic logic chip_on(input logic e1_n, input logic e2, input logic e3_n);
        return !e1_n && e2 && !e3_n;
    endfunction

    // Linear burst step on the low address bits, wrapping modulo 2**BURST_W.
    function automatic logic [BURST_W-1:0] beat_step(input logic [BURST_W-1:0] beat);
        return beat + BURST_W'(1);
    endfunction

endpackage

// File: rtl/sbs_cycle_decode.sv
module sbs_cycle_decode
    import sbs_pkg::*;
#(
    parameter int LANES = 4
) (
    input  logic             ce_a_n,
    input  logic             ce_b,
    input  logic             ce_c_n,
    input  logic             ads_cpu_n,
    input  logic             ads_ctl_n,
    input  logic             adv_n,
    input  logic             gw_n,
    input  logic             bwe_n,
    input  logic [LANES-1:0] lane_n,
    input  logic             sleep,
    output cmd_t             cmd,
    output logic [LANES-1:0] lane_mask
);

    logic enabled;
    logic cpu_live;
    logic wr_term;
    bus_e beat_dir;

    always_comb begin
        enabled  = chip_on(ce_a_n, ce_b, ce_c_n);
        // The processor strobe counts only while the first enable is active.
        cpu_live = !ads_cpu_n && !ce_a_n;
        wr_term  = !gw_n || (!bwe_n && (lane_n != {LANES{1'b1}}));
        beat_dir = wr_term ? BUS_WRITE : BUS_READ;

        if (!gw_n) begin
            lane_mask = {LANES{1'b1}};
        end else if (!bwe_n) begin
            lane_mask = ~lane_n;
        end else begin
            lane_mask = '0;
        end

        if (sleep) begin
            cmd = '{kind: CYC_SLEEP, dir: BUS_OFF};
        end else if (cpu_live) begin
            if (enabled) begin
                cmd = '{kind: CYC_BEGIN, dir: BUS_READ};
            end else begin
                cmd = '{kind: CYC_DESEL, dir: BUS_OFF};
            end
        end else if (!ads_ctl_n) begin
            if (enabled) begin
                cmd = '{kind: CYC_BEGIN, dir: beat_dir};
            end else begin
                cmd = '{kind: CYC_DESEL, dir: BUS_OFF};
            end
        end else if (!adv_n) begin
            cmd = '{kind: CYC_NEXT, dir: beat_dir};
        end else begin
            cmd = '{kind: CYC_HOLD, dir: beat_dir};
        end
    end

endmodule

// File: rtl/sbs_burst_seq.sv
module sbs_burst_seq
    import sbs_pkg::*;
#(
    parameter int ADDR_W = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  cmd_t              cmd,
    input  logic [ADDR_W-1:0] ext_addr,
    output logic [ADDR_W-1:0] addr_q,
    output bus_e              op_q,
    output logic              live_q,
    output logic [ADDR_W-1:0] beat_addr,
    output logic              mem_we
);

    localparam int HI_W = ADDR_W - BURST_W;

    logic beat_ok;

    always_comb begin
        beat_addr = addr_q;
        beat_ok   = 1'b0;
        case (cmd.kind)
            CYC_BEGIN: begin
                beat_addr = ext_addr;
                beat_ok   = 1'b1;
            end
            CYC_NEXT: begin
                beat_addr = {addr_q[ADDR_W-1:BURST_W], beat_step(addr_q[BURST_W-1:0])};
                beat_ok   = live_q;
            end
            CYC_HOLD: begin
                beat_ok   = live_q;
            end
            default: begin
                beat_ok   = 1'b0;
            end
        endcase
        mem_we = beat_ok && (cmd.dir == BUS_WRITE);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            addr_q <= '0;
            op_q   <= BUS_OFF;
            live_q <= 1'b0;
        end else if (cmd.kind == CYC_SLEEP || cmd.kind == CYC_DESEL) begin
            op_q   <= BUS_OFF;
            live_q <= 1'b0;
        end else if (beat_ok) begin
            addr_q <= beat_addr;
            op_q   <= cmd.dir;
            live_q <= 1'b1;
        end else begin
            op_q   <= BUS_OFF;
        end
    end

    // R3: a deselect closes the burst and leaves nothing to drive.
    p_desel_closes_r3: assert property (@(posedge clk) disable iff (rst)
        (cmd.kind == CYC_DESEL) |=> (op_q == BUS_OFF && !live_q));

    // R8: continue steps the low bits modulo 4 and keeps the upper bits.
    p_next_wraps_r8: assert property (@(posedge clk) disable iff (rst)
        (cmd.kind == CYC_NEXT && live_q) |=>
            (addr_q[ADDR_W-1:BURST_W] == $past(addr_q[ADDR_W-1:BURST_W])) &&
            (addr_q[BURST_W-1:0] == BURST_W'($past(addr_q[BURST_W-1:0]) + 1)));

    // R9: suspend keeps the burst address.
    p_hold_keeps_r9: assert property (@(posedge clk) disable iff (rst)
        (cmd.kind == CYC_HOLD && live_q) |=> $stable(addr_q));

    // R12: without an open burst, continue and suspend never write.
    p_dead_no_write_r12: assert property (@(posedge clk) disable iff (rst)
        (!live_q && (cmd.kind == CYC_NEXT || cmd.kind == CYC_HOLD)) |-> !mem_we);

    logic [HI_W-1:0] unused_hi;
    assign unused_hi = '0;

endmodule

// File: rtl/sbs_lane_array.sv
module sbs_lane_array #(
    parameter int ADDR_W = 6,
    parameter int LANES  = 4,
    parameter int LANE_W = 9
) (
    input  logic                    clk,
    input  logic                    we,
    input  logic [LANES-1:0]        lane_mask,
    input  logic [ADDR_W-1:0]       waddr,
    input  logic [LANES*LANE_W-1:0] wdata,
    input  logic [ADDR_W-1:0]       raddr,
    output logic [LANES*LANE_W-1:0] rdata
);

    localparam int DEPTH = 1 << ADDR_W;

    for (genvar k = 0; k < LANES; k++) begin : g_lane
        logic [LANE_W-1:0] mem [DEPTH];

        always_ff @(posedge clk) begin
            if (we && lane_mask[k]) begin
                mem[waddr] <= wdata[k*LANE_W +: LANE_W];
            end
        end

        // Flow-through read port.
        assign rdata[k*LANE_W +: LANE_W] = mem[raddr];
    end

endmodule

// File: rtl/sbs_sram_ctl.sv
module sbs_sram_ctl
    import sbs_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int LANES  = 4,
    parameter int LANE_W = 9
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    ce_a_n,
    input  logic                    ce_b,
    input  logic                    ce_c_n,
    input  logic                    ads_cpu_n,
    input  logic                    ads_ctl_n,
    input  logic                    adv_n,
    input  logic                    gw_n,
    input  logic                    bwe_n,
    input  logic [LANES-1:0]        lane_n,
    input  logic                    sleep,
    input  logic                    oe_n,
    input  logic [ADDR_W-1:0]       addr,
    inout  wire  [LANES*LANE_W-1:0] dq
);

    localparam int DATA_W = LANES * LANE_W;

    cmd_t              cmd;
    logic [LANES-1:0]  lane_mask;
    logic [ADDR_W-1:0] addr_q;
    logic [ADDR_W-1:0] beat_addr;
    bus_e              op_q;
    logic              live_q;
    logic              mem_we;
    logic [DATA_W-1:0] rdata;
    logic              bus_drive;

    sbs_cycle_decode #(.LANES(LANES)) u_decode (
        .ce_a_n    (ce_a_n),
        .ce_b      (ce_b),
        .ce_c_n    (ce_c_n),
        .ads_cpu_n (ads_cpu_n),
        .ads_ctl_n (ads_ctl_n),
        .adv_n     (adv_n),
        .gw_n      (gw_n),
        .bwe_n     (bwe_n),
        .lane_n    (lane_n),
        .sleep     (sleep),
        .cmd       (cmd),
        .lane_mask (lane_mask)
    );

    sbs_burst_seq #(.ADDR_W(ADDR_W)) u_seq (
        .clk       (clk),
        .rst       (rst),
        .cmd       (cmd),
        .ext_addr  (addr),
        .addr_q    (addr_q),
        .op_q      (op_q),
        .live_q    (live_q),
        .beat_addr (beat_addr),
        .mem_we    (mem_we)
    );

    sbs_lane_array #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_array (
        .clk       (clk),
        .we        (mem_we),
        .lane_mask (lane_mask),
        .waddr     (beat_addr),
        .wdata     (dq),
        .raddr     (addr_q),
        .rdata     (rdata)
    );

    // Output enable is combinational and masked outside read cycles.
    assign bus_drive = (op_q == BUS_READ) && !oe_n && !sleep;
    assign dq        = bus_drive ? rdata : {DATA_W{1'bz}};

    // R5: a processor-strobe start never writes.
    p_cpu_start_reads_r5: assert property (@(posedge clk) disable iff (rst)
        (!ads_cpu_n && !ce_a_n && !sleep) |-> !mem_we);

    // R2: sleep blocks writes and leaves the next period undriven.
    p_sleep_no_write_r2: assert property (@(posedge clk) disable iff (rst)
        sleep |-> !mem_we);
    p_sleep_quiet_r2: assert property (@(posedge clk) disable iff (rst)
        sleep |=> (op_q == BUS_OFF && !live_q));

    // R10: a write beat never leaves the bus driven afterwards.
    p_write_undriven_r10: assert property (@(posedge clk) disable iff (rst)
        (mem_we && cmd.dir == BUS_WRITE) |=> (op_q == BUS_WRITE));

endmodule

// File: tb/sbs_sram_ctl_test.sv
module sbs_sram_ctl_test;

    localparam int CLK_PERIOD = 10;
    localparam int AW = 6;
    localparam int NL = 4;
    localparam int LW = 9;
    localparam int DW = NL * LW;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          ce_a_n = 1'b0, ce_b = 1'b1, ce_c_n = 1'b0;
    logic          ads_cpu_n = 1'b1, ads_ctl_n = 1'b1, adv_n = 1'b1;
    logic          gw_n = 1'b1, bwe_n = 1'b1;
    logic [NL-1:0] lane_n = '1;
    logic          sleep = 1'b0, oe_n = 1'b1;
    logic [AW-1:0] addr = '0;
    logic [DW-1:0] tb_dq = '0;
    logic          tb_drv = 1'b0;
    wire  [DW-1:0] dq;

    int n_checks = 0;
    int n_err = 0;
    logic [DW-1:0] mdl [64];

    assign dq = tb_drv ? tb_dq : {DW{1'bz}};

    always #(CLK_PERIOD/2) clk = ~clk;

    sbs_sram_ctl #(.ADDR_W(AW), .LANES(NL), .LANE_W(LW)) uut (
        .clk(clk), .rst(rst), .ce_a_n(ce_a_n), .ce_b(ce_b), .ce_c_n(ce_c_n),
        .ads_cpu_n(ads_cpu_n), .ads_ctl_n(ads_ctl_n), .adv_n(adv_n),
        .gw_n(gw_n), .bwe_n(bwe_n), .lane_n(lane_n), .sleep(sleep),
        .oe_n(oe_n), .addr(addr), .dq(dq)
    );

    function automatic logic [DW-1:0] pat(input logic [5:0] a, input logic [2:0] s);
        return {s ^ 3'd3, a, s ^ 3'd2, a, s ^ 3'd1, a, s, a};
    endfunction

    task automatic check(input string tag, input logic [DW-1:0] got, input logic [DW-1:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_err++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    // One bus cycle: set controls, take the edge, release the bus, settle.
    task automatic cyc(input logic cpu_n, input logic ctl_n, input logic av_n,
                       input logic g_n, input logic b_n, input logic [NL-1:0] ln,
                       input logic [AW-1:0] a, input logic drv, input logic [DW-1:0] d);
        ads_cpu_n = cpu_n; ads_ctl_n = ctl_n; adv_n = av_n;
        gw_n = g_n; bwe_n = b_n; lane_n = ln; addr = a;
        tb_dq = d; tb_drv = drv;
        @(posedge clk);
        #1;
        tb_drv = 1'b0;
        ads_cpu_n = 1'b1; ads_ctl_n = 1'b1; gw_n = 1'b1; bwe_n = 1'b1; lane_n = '1;
        #1;
    endtask

    task automatic cpu_read(input logic [AW-1:0] a);
        oe_n = 1'b1;
        cyc(1'b0, 1'b1, 1'b1, 1'b1, 1'b1, '1, a, 1'b0, '0);
        oe_n = 1'b0;
        #1;
    endtask

    task automatic t_reset;
        oe_n = 1'b0;
        cyc(1'b1, 1'b1, 1'b0, 1'b1, 1'b1, '1, 6'h00, 1'b0, '0);
        check("R1 continue after reset", dq, {DW{1'bz}});
        cyc(1'b1, 1'b1, 1'b1, 1'b1, 1'b1, '1, 6'h00, 1'b0, '0);
        check("R1 suspend after reset", dq, {DW{1'bz}});
    endtask

    task automatic t_write_burst;
        oe_n = 1'b1;
        cyc(1'b1, 1'b0, 1'b1, 1'b0, 1'b1, '1, 6'h12, 1'b1, pat(6'h12, 3'd1));
        mdl[6'h12] = pat(6'h12, 3'd1);
        oe_n = 1'b0;
        #1;
        check("R10 bus released in write with oe low", dq, {DW{1'bz}});
        cyc(1'b1, 1'b1, 1'b0, 1'b0, 1'b1, '1, 6'h00, 1'b1, pat(6'h13, 3'd1));
        mdl[6'h13] = pat(6'h13, 3'd1);
        cyc(1'b1, 1'b1, 1'b0, 1'b0, 1'b1, '1, 6'h00, 1'b1, pat(6'h10, 3'd1));
        mdl[6'h10] = pat(6'h10, 3'd1);
        cyc(1'b1, 1'b1, 1'b0, 1'b0, 1'b1, '1, 6'h00, 1'b1, pat(6'h11, 3'd1));
        mdl[6'h11] = pat(6'h11, 3'd1);
        check("R6 R10 continue write leaves bus undriven", dq, {DW{1'bz}});
    endtask

    task automatic t_read_burst;
        oe_n = 1'b1;
        // Processor strobe start with write controls and bus data: still a read.
        cyc(1'b0, 1'b1, 1'b1, 1'b0, 1'b0, '0, 6'h13, 1'b1, pat(6'h13, 3'd7));
        oe_n = 1'b0;
        #1;
        check("R5 R13 cpu start reads", dq, mdl[6'h13]);
        cyc(1'b1, 1'b1, 1'b0, 1'b1, 1'b1, '1, 6'h00, 1'b0, '0);
        check("R8 continue wraps 3 to 0", dq, mdl[6'h10]);
        cyc(1'b1, 1'b1, 1'b1, 1'b1, 1'b1, '1, 6'h00, 1'b0, '0);
        check("R9 suspend holds", dq, mdl[6'h10]);
        cyc(1'b1, 1'b1, 1'b0, 1'b1, 1'b1, '1, 6'h00, 1'b0, '0);
        check("R8 R13 continue to next", dq, mdl[6'h11]);
        oe_n = 1'b1;
        #1;
        check("R10 oe high releases bus", dq, {DW{1'bz}});
        oe_n = 1'b0;
        #1;
        check("R10 oe low drives without clock", dq, mdl[6'h11]);
        cpu_read(6'h13);
        check("R5 word not written by cpu start", dq, pat(6'h13, 3'd1));
    endtask

    task automatic t_write_term;
        logic [DW-1:0] merged;
        oe_n = 1'b1;
        cyc(1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 4'b1111, 6'h10, 1'b0, '0);
        oe_n = 1'b0;
        #1;
        check("R7 byte-write with no lane is a read", dq, mdl[6'h10]);
        oe_n = 1'b1;
        cyc(1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 4'b1010, 6'h11, 1'b1, pat(6'h11, 3'd5));
        merged = mdl[6'h11];
        merged[0 +: LW]    = pat(6'h11, 3'd5) >> 0;
        merged[2*LW +: LW] = pat(6'h11, 3'd5) >> (2*LW);
        mdl[6'h11] = merged;
        cyc(1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 4'b0000, 6'h12, 1'b0, '0);
        oe_n = 1'b0;
        #1;
        check("R7 lanes without byte-write enable is a read", dq, mdl[6'h12]);
        cpu_read(6'h11);
        check("R11 only lanes 0 and 2 written", dq, mdl[6'h11]);
        cpu_read(6'h13);
        check("R11 global write stored all lanes", dq, pat(6'h13, 3'd1));
    endtask

    task automatic t_deselect;
        cpu_read(6'h10);
        check("R3 read before deselect", dq, mdl[6'h10]);
        ce_b = 1'b0;
        cyc(1'b1, 1'b0, 1'b1, 1'b1, 1'b1, '1, 6'h11, 1'b0, '0);
        check("R3 controller strobe with second enable low", dq, {DW{1'bz}});
        ce_b = 1'b1;
        cyc(1'b1, 1'b1, 1'b0, 1'b1, 1'b1, '1, 6'h00, 1'b0, '0);
        check("R12 continue after deselect", dq, {DW{1'bz}});
        oe_n = 1'b1;
        cyc(1'b1, 1'b1, 1'b1, 1'b0, 1'b1, '1, 6'h00, 1'b1, pat(6'h10, 3'd6));
        oe_n = 1'b0;
        #1;
        check("R12 suspend write after deselect", dq, {DW{1'bz}});
        ce_c_n = 1'b1;
        cyc(1'b0, 1'b1, 1'b1, 1'b1, 1'b1, '1, 6'h12, 1'b0, '0);
        check("R3 cpu strobe with third enable high", dq, {DW{1'bz}});
        ce_c_n = 1'b0;
        ce_a_n = 1'b1;
        cyc(1'b1, 1'b0, 1'b1, 1'b1, 1'b1, '1, 6'h12, 1'b0, '0);
        check("R3 controller strobe with first enable high", dq, {DW{1'bz}});
        ce_a_n = 1'b0;
        cpu_read(6'h10);
        check("R12 word intact after dead write", dq, mdl[6'h10]);
    endtask

    task automatic t_enable_a;
        cpu_read(6'h12);
        ce_a_n = 1'b1;
        cyc(1'b0, 1'b1, 1'b1, 1'b1, 1'b1, '1, 6'h30, 1'b0, '0);
        check("R4 ignored cpu strobe acts as suspend", dq, mdl[6'h12]);
        cyc(1'b0, 1'b1, 1'b0, 1'b1, 1'b1, '1, 6'h30, 1'b0, '0);
        check("R4 ignored cpu strobe acts as continue", dq, mdl[6'h13]);
        ce_a_n = 1'b0;
    endtask

    task automatic t_sleep;
        cpu_read(6'h13);
        oe_n = 1'b1;
        sleep = 1'b1;
        cyc(1'b1, 1'b0, 1'b1, 1'b0, 1'b1, '1, 6'h13, 1'b1, pat(6'h13, 3'd3));
        oe_n = 1'b0;
        #1;
        check("R2 sleep keeps bus released", dq, {DW{1'bz}});
        cyc(1'b0, 1'b1, 1'b0, 1'b1, 1'b1, '1, 6'h10, 1'b0, '0);
        check("R2 sleep ignores cpu strobe", dq, {DW{1'bz}});
        sleep = 1'b0;
        cyc(1'b1, 1'b1, 1'b0, 1'b1, 1'b1, '1, 6'h00, 1'b0, '0);
        check("R2 continue after sleep", dq, {DW{1'bz}});
        cpu_read(6'h13);
        check("R2 no write during sleep", dq, mdl[6'h13]);
    endtask

    initial begin : watchdog
        #(CLK_PERIOD * 20000);
        n_checks++;
        n_err++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
        $finish;
    end

    initial begin : main
        repeat (3) @(posedge clk);
        #1;
        rst = 1'b0;
        t_reset();
        t_write_burst();
        t_read_burst();
        t_write_term();
        t_deselect();
        t_enable_a();
        t_sleep();
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
        $finish;
    end

endmodule